// File: doc/BRIEF.md
# Sticky Integrity Observation Scan Chain

This block is a chain of observation cells placed at the receiving end of a group of interconnect lines under signal-integrity test. Each cell watches one line and keeps a sticky pass/fail flag. The flag is set whenever the value received on that line differs from the value it should carry at a sampling strobe. The strobe fires a programmable number of clock cycles after each new test pattern is applied, so it stands in for an acceptable-delay window: a line that settles to the right value before the strobe is not a fault. A line that is still wrong at the strobe is one.

The flags are only read when the test controller chooses to read them: once after a complete run, after each seed, or after every pattern. Each choice gives a different balance between scan time and how precisely a fault can be located. A capture strobe copies the flags into the scan register. A shift strobe moves them one place per cycle toward the serial output. In conventional mode the cell is a plain observe-only boundary cell: capture loads the received line value and the sticky flag is left untouched.

Top module: `integrity_obs_chain`

## Requirements
- R1: After a synchronous reset, every sticky flag and every scan register bit is 0, so `scan_out` is 0 and a flag readout returns all zeros.
- R2: With `mode_sel`=1 and `sense_en`=1, a lane whose `expected` and `received` bits differ in the strobe cycle sets its sticky flag. Lanes that match leave their flags unchanged. Bit i of each vector belongs to lane i.
- R3: The strobe occurs exactly once, in the cycle that comes `strobe_dly` cycles after the cycle in which `pattern_upd` was sampled high, with `strobe_dly` taken at that same edge. A mismatch that is corrected by the strobe cycle is not a violation, and a mismatch present only in cycles with no strobe is ignored.
- R4: A set flag stays set across later matching patterns and across any number of captures and readouts.
- R5: With `sense_en`=0, violations are ignored and every flag keeps its value.
- R6: A capture (`capture_dr`=1) loads each lane's sticky flag into its scan bit when `mode_sel`=1, and loads the lane's `received` bit when `mode_sel`=0.
- R7: Each shift (`shift_dr`=1) moves every scan bit one lane toward the output. Lane 0 takes `scan_in`, and `scan_out` shows the highest lane's bit. After a capture, the bits therefore leave in the order lane LANES-1 down to lane 0, followed by the bits shifted in from `scan_in`.
- R8: `flag_clr`=1 clears every sticky flag at the next edge and takes priority over a violation in the same cycle. It does not disturb the scan register.
- R9: With `mode_sel`=0, violations do not set any flag.
- R10: When `capture_dr` and `shift_dr` are both high, the capture is performed and the shift is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high test-logic reset |
| mode_sel | input | 1 | 1 = integrity mode, 0 = conventional observe-only |
| sense_en | input | 1 | Enables violations to set the sticky flags |
| capture_dr | input | 1 | Capture strobe from the TAP controller |
| shift_dr | input | 1 | Shift strobe from the TAP controller |
| flag_clr | input | 1 | Clears all sticky flags |
| pattern_upd | input | 1 | A new test pattern is driven onto the lines this cycle |
| strobe_dly | input | DLY_W | Cycles from pattern update to the sampling strobe |
| expected | input | LANES | Value each line should carry |
| received | input | LANES | Value observed at each line's receiver |
| scan_in | input | 1 | Serial input into lane 0 |
| scan_out | output | 1 | Serial output from the highest lane |

## Verification
The bench moves the point where a late line becomes correct to either side of the strobe cycle. A timer that is off by one cycle would then flag a line that had settled in time, or miss one that had not. It raises `flag_clr` in the very cycle of a violation. A design that lets the set win would leave a flag behind after the clear. It shifts a few cycles past the chain length and pulses capture together with shift. A reversed chain, a lost `scan_in` path or a shift that overrides capture all show up as wrong bit order or wrong bit values. It also runs readouts in conventional mode and with sensing disabled, and repeats readouts after the flags are set. A cell that ignores the mode, ignores the enable, or clears its flag on capture would report a different flag pattern.

// File: rtl/iobs_pkg.sv
package iobs_pkg;

    // Per-cell control bundle, broadcast to every lane.
    typedef struct packed {
        logic mode_sel;   // 1: integrity mode, 0: conventional observe-only
        logic sense_en;   // violations may set the sticky flag
        logic capture;    // load scan register
        logic shift;      // shift scan register toward the output
        logic flag_clr;   // clear sticky flag
    } cell_ctrl_t;

    typedef enum logic [1:0] {
        SC_HOLD    = 2'd0,
        SC_CAPTURE = 2'd1,
        SC_SHIFT   = 2'd2
    } scan_op_e;

    // Capture has priority over shift.
    function automatic scan_op_e scan_op(input logic cap, input logic shf);
        if (cap)      return SC_CAPTURE;
        else if (shf) return SC_SHIFT;
        else          return SC_HOLD;
    endfunction

    // Value loaded on capture: the flag in integrity mode, the line otherwise.
    function automatic logic capture_src(input logic mode, input logic flag,
                                         input logic line_val);
        return mode ? flag : line_val;
    endfunction

    // A line is in violation when it is strobed and differs from the expected value.
    function automatic logic line_bad(input logic strobe, input logic exp_v,
                                      input logic rcv_v);
        return strobe & ~(exp_v ~^ rcv_v);
    endfunction

endpackage

// File: rtl/iobs_strobe_timer.sv
module iobs_strobe_timer #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pattern_upd,
    input  logic [DLY_W-1:0] strobe_dly,
    output logic             strobe
);
    logic [DLY_W-1:0] wait_cnt;
    logic             armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            wait_cnt <= '0;
        end else if (pattern_upd) begin
            armed    <= 1'b1;
            wait_cnt <= strobe_dly;
        end else if (armed) begin
            if (wait_cnt == '0) armed <= 1'b0;
            else                wait_cnt <= wait_cnt - 1'b1;
        end
    end

    assign strobe = armed && (wait_cnt == '0);

    // R3: one strobe per pattern update
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
        (strobe && !pattern_upd) |=> !strobe);

    // R3: zero delay strobes in the cycle right after the update
    a_r3_zero_delay: assert property (@(posedge clk) disable iff (rst)
        (pattern_upd && strobe_dly == '0) |=> strobe);

    // R3: non-zero delay does not strobe immediately
    a_r3_no_early: assert property (@(posedge clk) disable iff (rst)
        (pattern_upd && strobe_dly != '0) |=> !strobe);

endmodule

// File: rtl/iobs_lane_cmp.sv
module iobs_lane_cmp
    import iobs_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             strobe,
    input  logic [LANES-1:0] expected,
    input  logic [LANES-1:0] received,
    output logic [LANES-1:0] viol
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign viol[g] = line_bad(strobe, expected[g], received[g]);
    end
endmodule

// File: rtl/iobs_cell.sv
module iobs_cell
    import iobs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cell_ctrl_t ctrl,
    input  logic       viol,
    input  logic       line_val,
    input  logic       chain_in,
    output logic       chain_out
);
    logic sticky;
    logic scan_q;

    always_ff @(posedge clk) begin
        if (rst || ctrl.flag_clr)
            sticky <= 1'b0;
        else if (ctrl.mode_sel && ctrl.sense_en && viol)
            sticky <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scan_q <= 1'b0;
        end else begin
            unique case (scan_op(ctrl.capture, ctrl.shift))
                SC_CAPTURE: scan_q <= capture_src(ctrl.mode_sel, sticky, line_val);
                SC_SHIFT:   scan_q <= chain_in;
                default:    scan_q <= scan_q;
            endcase
        end
    end

    assign chain_out = scan_q;

    // R4: a set flag stays set until cleared
    a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
        (sticky && !ctrl.flag_clr) |=> sticky);

    // R8: clear wins
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        ctrl.flag_clr |=> !sticky);

    // R5 / R9: flag holds when sensing is off or in conventional mode
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!(ctrl.mode_sel && ctrl.sense_en) && !ctrl.flag_clr) |=> $stable(sticky));

    // R6: integrity-mode capture loads the flag
    a_r6_capture_flag: assert property (@(posedge clk) disable iff (rst)
        (ctrl.capture && ctrl.mode_sel) |=> (scan_q == $past(sticky)));

    // R7 / R10: shift without capture takes the neighbour's bit
    a_r7_shift: assert property (@(posedge clk) disable iff (rst)
        (ctrl.shift && !ctrl.capture) |=> (scan_q == $past(chain_in)));

endmodule

// File: rtl/integrity_obs_chain.sv
module integrity_obs_chain
    import iobs_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_sel,
    input  logic             sense_en,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             flag_clr,
    input  logic             pattern_upd,
    input  logic [DLY_W-1:0] strobe_dly,
    input  logic [LANES-1:0] expected,
    input  logic [LANES-1:0] received,
    input  logic             scan_in,
    output logic             scan_out
);
    localparam int LAST = LANES - 1;

    logic             strobe;
    logic [LANES-1:0] viol;
    logic [LANES:0]   chain;
    cell_ctrl_t       ctrl;

    assign ctrl = '{mode_sel: mode_sel, sense_en: sense_en, capture: capture_dr,
                    shift: shift_dr, flag_clr: flag_clr};

    iobs_strobe_timer #(.DLY_W(DLY_W)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .pattern_upd (pattern_upd),
        .strobe_dly  (strobe_dly),
        .strobe      (strobe)
    );

    iobs_lane_cmp #(.LANES(LANES)) u_cmp (
        .strobe   (strobe),
        .expected (expected),
        .received (received),
        .viol     (viol)
    );

    assign chain[0] = scan_in;

    for (genvar g = 0; g < LANES; g++) begin : g_cell
        iobs_cell u_cell (
            .clk       (clk),
            .rst       (rst),
            .ctrl      (ctrl),
            .viol      (viol[g]),
            .line_val  (received[g]),
            .chain_in  (chain[g]),
            .chain_out (chain[g+1])
        );
    end

    assign scan_out = chain[LAST+1];

    // R7: output moves only on capture or shift
    a_r7_out_stable: assert property (@(posedge clk) disable iff (rst)
        (!capture_dr && !shift_dr) |=> $stable(scan_out));

    // R2: no violation reported outside a strobe
    a_r2_strobe_gate: assert property (@(posedge clk) disable iff (rst)
        !strobe |-> (viol == '0));

endmodule

// File: tb/integrity_obs_chain_test.sv
module integrity_obs_chain_test;
    localparam int LANES = 4;
    localparam int DLY_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             mode_sel = 1'b0;
    logic             sense_en = 1'b0;
    logic             capture_dr = 1'b0;
    logic             shift_dr = 1'b0;
    logic             flag_clr = 1'b0;
    logic             pattern_upd = 1'b0;
    logic [DLY_W-1:0] strobe_dly = '0;
    logic [LANES-1:0] expected = '0;
    logic [LANES-1:0] received = '0;
    logic             scan_in = 1'b0;
    logic             scan_out;

    int checks = 0;
    int errors = 0;
    logic [LANES-1:0] model = '0;
    logic mon_on = 1'b0;

    typedef struct {
        logic  bitv;
        string tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    integrity_obs_chain #(.LANES(LANES), .DLY_W(DLY_W)) uut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .sense_en(sense_en),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .flag_clr(flag_clr),
        .pattern_upd(pattern_upd), .strobe_dly(strobe_dly),
        .expected(expected), .received(received),
        .scan_in(scan_in), .scan_out(scan_out)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: scan_out=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: pops one expected bit per shift cycle.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (mon_on && sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check(scan_out, it.bitv, it.tag);
            end
        end
    end

    // Apply one pattern. The line shows 'bad' until negedge k, then 'good'.
    task automatic apply_vec(input logic [LANES-1:0] exp_v, input logic [LANES-1:0] bad,
                             input logic [LANES-1:0] good, input int k, input int dly,
                             input logic clr_at_strobe);
        logic [LANES-1:0] at_strobe;
        @(negedge clk);
        expected    = exp_v;
        received    = bad;
        strobe_dly  = DLY_W'(dly);
        pattern_upd = 1'b1;
        for (int j = 1; j <= dly + 3; j++) begin
            @(negedge clk);
            pattern_upd = 1'b0;
            if (j == k) received = good;
            flag_clr = (clr_at_strobe && j == dly + 1);
        end
        flag_clr = 1'b0;
        at_strobe = (k <= dly + 1) ? good : bad;
        if (clr_at_strobe) model = '0;
        else if (mode_sel && sense_en) model = model | (exp_v ^ at_strobe);
    endtask

    // Capture then shift out LANES + extra bits; expectations go to the scoreboard.
    task automatic readout(input logic cap_mode, input int extra, input logic sin,
                           input logic both, input string tag);
        logic [LANES-1:0] cap;
        @(negedge clk);
        mode_sel   = cap_mode;
        cap        = cap_mode ? model : received;
        for (int i = LANES - 1; i >= 0; i--) sb.push_back('{cap[i], tag});
        for (int i = 0; i < extra; i++) sb.push_back('{sin, tag});
        capture_dr = 1'b1;
        shift_dr   = both;
        @(negedge clk);
        capture_dr = 1'b0;
        shift_dr   = 1'b1;
        scan_in    = sin;
        mon_on     = 1'b1;
        repeat (LANES + extra - 1) @(negedge clk);
        @(negedge clk);
        shift_dr = 1'b0;
        mon_on   = 1'b0;
        scan_in  = 1'b0;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL %s: %0d bits left unread, expected 0", tag, sb.size());
            sb.delete();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(scan_out, 1'b0, "R1 reset scan_out");
        mode_sel = 1'b1; sense_en = 1'b1;
        readout(1'b1, 0, 1'b0, 1'b0, "R1 reset flags");

        // R2: lane 1 never settles
        apply_vec(4'b1010, 4'b1000, 4'b1000, 99, 2, 1'b0);
        readout(1'b1, 0, 1'b0, 1'b0, "R2 R7 lane1 flag");

        // R4: matching pattern and repeated readout keep the flag
        apply_vec(4'b0110, 4'b0110, 4'b0110, 99, 1, 1'b0);
        readout(1'b1, 0, 1'b0, 1'b0, "R4 sticky");

        // R8: clear
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        model = '0;
        readout(1'b1, 0, 1'b0, 1'b0, "R8 clear");

        // R3: settles exactly at the strobe -> no violation
        apply_vec(4'b0101, 4'b1010, 4'b0101, 4, 3, 1'b0);
        readout(1'b1, 0, 1'b0, 1'b0, "R3 settled in time");
        // R3: settles one cycle late -> violation on all lanes
        apply_vec(4'b0101, 4'b1010, 4'b0101, 5, 3, 1'b0);
        readout(1'b1, 0, 1'b0, 1'b0, "R3 late settle");
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        model = '0;

        // R3: mismatch with no strobe is ignored
        apply_vec(4'b0011, 4'b0011, 4'b0011, 99, 0, 1'b0);
        @(negedge clk); received = 4'b1100;
        repeat (5) @(negedge clk);
        received = 4'b0011;
        readout(1'b1, 0, 1'b0, 1'b0, "R3 no strobe");

        // R5: sensing disabled keeps existing flag and ignores new ones
        apply_vec(4'b0000, 4'b0001, 4'b0001, 99, 0, 1'b0);
        sense_en = 1'b0;
        apply_vec(4'b0000, 4'b1110, 4'b1110, 99, 2, 1'b0);
        readout(1'b1, 0, 1'b0, 1'b0, "R5 hold when disabled");
        sense_en = 1'b1;

        // R9: conventional mode does not set flags
        mode_sel = 1'b0;
        apply_vec(4'b0000, 4'b0110, 4'b0110, 99, 1, 1'b0);
        // R6: conventional capture loads the received lines (0110)
        readout(1'b0, 0, 1'b0, 1'b0, "R6 conventional capture");
        readout(1'b1, 0, 1'b0, 1'b0, "R9 no flag in conventional mode");

        // R7: scan_in reaches the output after LANES shifts
        readout(1'b1, 3, 1'b1, 1'b0, "R7 scan_in path");

        // R10: capture and shift together -> capture only
        readout(1'b1, 0, 1'b0, 1'b1, "R10 capture wins");

        // R8: clear in the strobe cycle beats the violation
        mode_sel = 1'b1;
        apply_vec(4'b1111, 4'b0000, 4'b0000, 99, 0, 1'b1);
        readout(1'b1, 0, 1'b0, 1'b0, "R8 clear beats set");

        // R2: different pattern after clear, longer delay
        apply_vec(4'b1001, 4'b0001, 4'b0001, 99, 6, 1'b0);
        readout(1'b1, 0, 1'b0, 1'b0, "R2 lane3 flag");

        // R1: reset mid-test clears flags
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model = '0;
        check(scan_out, 1'b0, "R1 reset after run");
        readout(1'b1, 0, 1'b0, 1'b0, "R1 flags after reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule